// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block turns bytes written by a host into framed asynchronous serial characters on a single line. The host writes a byte into a one-entry holding register and then clears the empty flag. That cleared flag is what tells the engine new data is waiting. On the next bit tick the engine copies the byte into its shift register and sets the empty flag again, so the host can queue the following byte while the current one is still going out.

A frame is built from four parts:
- a low start bit;
- seven or eight data bits, sent lowest bit first;
- an optional extra slot, carrying either an even/odd parity bit or a host-supplied address/data marker;
- one or two high stop bits.

At the start of the first stop bit the engine looks at the empty flag again:
- If fresh data is waiting, the next start bit follows the last stop bit with no gap.
- Otherwise the engine raises a transmit-end flag and the line rests high.

An external tick input paces every bit cell. Two level interrupt requests report "holding register empty" and "transmission ended", each gated by its own enable.

Top module: `ser_tx_core`

## Requirements
- R1: After reset, txd is 1, empty_flag is 1 and end_flag is 1.
- R2: A write on hold_wr followed by a pulse on empty_clr clears empty_flag. At the next tick with tx_en at 1 the engine loads the byte, sets empty_flag back to 1 and clears end_flag. The start bit begins in the cycle after that tick.
- R3: A frame is, in time order: one start cell at 0, the data bits with bit 0 first, then one stop cell at 1, or two stop cells when stop_two is 1.
- R4: With len_short at 1 only bits 6..0 are sent, so bit 7 of the written byte has no effect on the line. With len_short at 0 all eight bits are sent.
- R5: An extra slot follows the data whenever par_en or mp_en is 1. With par_en at 1 and mp_en at 0 the slot holds the XOR of the sent data bits when par_odd is 0, and the inverse of that XOR when par_odd is 1.
- R6: With mp_en at 1 the slot carries mp_bit (1 marks an address frame, 0 a data frame), whatever par_en is.
- R7: stop_two at 0 gives one stop cell; at 1 it gives two.
- R8: Every bit cell lasts exactly one tick period. txd changes only in the cycle after a tick.
- R9: If empty_flag is 0 when the first stop cell begins, that data is loaded at once (empty_flag returns to 1), and its start cell directly follows the last stop cell.
- R10: If empty_flag is 1 when the first stop cell begins, end_flag becomes 1 and txd stays 1 after the stop cells until a new frame starts.
- R11: empty_irq equals empty_flag AND empty_ie, and end_irq equals end_flag AND end_ie, as levels.
- R12: While tx_en is 0, txd is 1, no frame is loaded and the engine changes neither flag. A byte queued meanwhile goes out once tx_en returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | One-cycle pulse marking each bit-cell boundary |
| hold_wr | input | 1 | Write strobe for the holding register |
| hold_wdata | input | DATA_W | Byte to write |
| empty_clr | input | 1 | Host pulse clearing the empty flag (hands data to the engine) |
| tx_en | input | 1 | Transmit enable |
| len_short | input | 1 | 1 selects seven data bits, 0 selects eight |
| par_en | input | 1 | Insert a parity slot |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| mp_en | input | 1 | Slot carries mp_bit instead of parity |
| mp_bit | input | 1 | Address (1) / data (0) marker for the slot |
| stop_two | input | 1 | 1 selects two stop cells |
| empty_ie | input | 1 | Enable for empty_irq |
| end_ie | input | 1 | Enable for end_irq |
| txd | output | 1 | Serial line, idle high |
| empty_irq | output | 1 | Holding-empty request (level) |
| end_irq | output | 1 | Transmit-end request (level) |
| empty_flag | output | 1 | Holding register empty flag |
| end_flag | output | 1 | Transmit-end flag |

## Verification
The assertions assume three things about the inputs:
- tick is a single-cycle pulse;
- the format inputs stay steady while frames are chained;
- empty_clr is pulsed only after a fresh write.

Under those assumptions they can tie every line change to a preceding tick, and every rise of the empty or end flag to the matching engine event.

The bench keeps within these limits:
- It produces ticks from a fixed divider.
- It changes format only while the line is idle.
- It always writes and then clears in consecutive cycles.

Every cycle of every bit cell is then compared against a frame assembled arithmetically from the byte and the format.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_SLOT  = 3'd3,
    ST_STOP1 = 3'd4,
    ST_STOP2 = 3'd5
  } txst_e;

  typedef struct packed {
    logic short_len;
    logic slot_on;
    logic slot_val;
    logic two_stop;
  } fmt_t;

endpackage

// File: rtl/ser_tx_slot.sv
module ser_tx_slot #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data,
  input  logic              short_len,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              mp_en,
  input  logic              mp_bit,
  output logic              slot_on,
  output logic              slot_val
);

  logic [DATA_W-1:0] used;
  logic              par_even;

  // Top bit is dropped in short-character mode; lower bits always count.
  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    if (i == DATA_W - 1) begin : g_top
      assign used[i] = data[i] & ~short_len;
    end else begin : g_low
      assign used[i] = data[i];
    end
  end

  assign par_even = ^used;

  always_comb begin
    slot_on  = par_en | mp_en;
    slot_val = mp_en ? mp_bit : (par_even ^ par_odd);
  end

endmodule

// File: rtl/ser_tx_hold.sv
module ser_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_clr,
  input  logic              eng_load,
  input  logic              eng_end,
  output logic [DATA_W-1:0] hold_q,
  output logic              empty_q,
  output logic              end_q
);

  logic [DATA_W-1:0] hold_d;
  logic              empty_d;
  logic              end_d;

  always_comb begin
    hold_d  = hold_q;
    empty_d = empty_q;
    end_d   = end_q;
    if (host_wr) begin
      hold_d = host_wdata;
    end
    // engine set has priority over host clear
    if (eng_load) begin
      empty_d = 1'b1;
    end else if (host_clr) begin
      empty_d = 1'b0;
    end
    if (eng_load) begin
      end_d = 1'b0;
    end else if (eng_end) begin
      end_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q  <= '0;
      empty_q <= 1'b1;
      end_q   <= 1'b1;
    end else begin
      hold_q  <= hold_d;
      empty_q <= empty_d;
      end_q   <= end_d;
    end
  end

  // R2: the engine only takes data the host has handed over
  assert_load_when_full_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    eng_load |-> !empty_q);

  // R2: a load leaves the empty flag set
  assert_load_sets_empty_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    eng_load |=> empty_q);

  // R10: end flag rises only on an engine end event
  assert_end_source_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(end_q) |-> $past(eng_end));

endmodule

// File: rtl/ser_tx_seq.sv
module ser_tx_seq
  import ser_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              tick,
  input  logic              tx_en,
  input  logic [DATA_W-1:0] hold_q,
  input  logic              empty_q,
  input  fmt_t              fmt_in,
  output logic              eng_load,
  output logic              eng_end,
  output logic              line
);

  localparam int CW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CW-1:0] LAST_LONG  = CW'(DATA_W - 1);
  localparam logic [CW-1:0] LAST_SHORT = CW'(DATA_W - 2);

  txst_e             st_q, st_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  fmt_t              fmt_q, fmt_d;
  logic              chain_q, chain_d;
  logic              stop2_q, stop2_d;
  logic              stop_sample;
  logic              finish;
  logic [CW-1:0]     last_idx;

  assign last_idx = fmt_q.short_len ? LAST_SHORT : LAST_LONG;

  always_comb begin
    st_d        = st_q;
    cnt_d       = cnt_q;
    sh_d        = sh_q;
    fmt_d       = fmt_q;
    chain_d     = chain_q;
    stop2_d     = stop2_q;
    eng_load    = 1'b0;
    eng_end     = 1'b0;
    stop_sample = 1'b0;
    finish      = 1'b0;
    if (!tx_en) begin
      st_d    = ST_IDLE;
      chain_d = 1'b0;
    end else if (tick) begin
      unique case (st_q)
        ST_IDLE: begin
          if (!empty_q) begin
            eng_load = 1'b1;
            st_d     = ST_START;
          end
        end
        ST_START: begin
          st_d  = ST_DATA;
          cnt_d = '0;
        end
        ST_DATA: begin
          sh_d = sh_q >> 1;
          if (cnt_q == last_idx) begin
            st_d        = fmt_q.slot_on ? ST_SLOT : ST_STOP1;
            stop_sample = ~fmt_q.slot_on;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_SLOT: begin
          st_d        = ST_STOP1;
          stop_sample = 1'b1;
        end
        ST_STOP1: begin
          if (stop2_q) begin
            st_d = ST_STOP2;
          end else begin
            finish = 1'b1;
          end
        end
        ST_STOP2: finish = 1'b1;
        default:  st_d = ST_IDLE;
      endcase
      if (stop_sample) begin
        stop2_d = fmt_q.two_stop;
        if (!empty_q) begin
          eng_load = 1'b1;
          chain_d  = 1'b1;
        end else begin
          eng_end = 1'b1;
          chain_d = 1'b0;
        end
      end
      if (finish) begin
        st_d    = chain_q ? ST_START : ST_IDLE;
        chain_d = 1'b0;
      end
      if (eng_load) begin
        sh_d  = hold_q;
        fmt_d = fmt_in;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      fmt_q   <= '0;
      chain_q <= 1'b0;
      stop2_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      fmt_q   <= fmt_d;
      chain_q <= chain_d;
      stop2_q <= stop2_d;
    end
  end

  always_comb begin
    unique case (st_q)
      ST_START: line = 1'b0;
      ST_DATA:  line = sh_q[0];
      ST_SLOT:  line = fmt_q.slot_val;
      default:  line = 1'b1;
    endcase
  end

  // R8: the line moves only right after a tick
  assert_cell_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (tx_en && $past(tx_en) && (line != $past(line))) |-> $past(tick));

  // R8: loads happen only on a tick
  assert_load_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    eng_load |-> (tick && tx_en));

  // R9: a pending frame follows the last stop cell at once
  assert_chain_start_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (tx_en && tick && chain_q && ((st_q == ST_STOP2) || (st_q == ST_STOP1 && !stop2_q)))
      |=> (!tx_en || !line));

endmodule

// File: rtl/ser_tx_core.sv
module ser_tx_core
  import ser_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              hold_wr,
  input  logic [DATA_W-1:0] hold_wdata,
  input  logic              empty_clr,
  input  logic              tx_en,
  input  logic              len_short,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              mp_en,
  input  logic              mp_bit,
  input  logic              stop_two,
  input  logic              empty_ie,
  input  logic              end_ie,
  output logic              txd,
  output logic              empty_irq,
  output logic              end_irq,
  output logic              empty_flag,
  output logic              end_flag
);

  logic [1:0]        rst_sync;
  logic              rst_ni;
  logic [DATA_W-1:0] hold_q;
  logic              eng_load;
  logic              eng_end;
  logic              line;
  logic              slot_on;
  logic              slot_val;
  fmt_t              fmt_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_ni = rst_sync[1];

  ser_tx_slot #(.DATA_W(DATA_W)) u_slot (
    .data      (hold_q),
    .short_len (len_short),
    .par_en    (par_en),
    .par_odd   (par_odd),
    .mp_en     (mp_en),
    .mp_bit    (mp_bit),
    .slot_on   (slot_on),
    .slot_val  (slot_val)
  );

  always_comb begin
    fmt_in.short_len = len_short;
    fmt_in.slot_on   = slot_on;
    fmt_in.slot_val  = slot_val;
    fmt_in.two_stop  = stop_two;
  end

  ser_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .host_wr    (hold_wr),
    .host_wdata (hold_wdata),
    .host_clr   (empty_clr),
    .eng_load   (eng_load),
    .eng_end    (eng_end),
    .hold_q     (hold_q),
    .empty_q    (empty_flag),
    .end_q      (end_flag)
  );

  ser_tx_seq #(.DATA_W(DATA_W)) u_seq (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .tick     (tick),
    .tx_en    (tx_en),
    .hold_q   (hold_q),
    .empty_q  (empty_flag),
    .fmt_in   (fmt_in),
    .eng_load (eng_load),
    .eng_end  (eng_end),
    .line     (line)
  );

  assign txd       = line | ~tx_en;
  assign empty_irq = empty_flag & empty_ie;
  assign end_irq   = end_flag & end_ie;

  // R12: with the engine disabled only the host may touch the flags
  assert_idle_flags_R12: assert property (@(posedge clk) disable iff (!rst_ni)
    (!tx_en && !empty_clr) |=> ($stable(empty_flag) && $stable(end_flag)));

  // R12: a disabled engine keeps the line high
  assert_idle_line_R12: assert property (@(posedge clk) disable iff (!rst_ni)
    (!tx_en && $past(!tx_en)) |-> txd);

endmodule

// File: tb/ser_tx_core_tb.sv
`timescale 1ns/1ps
module ser_tx_core_tb;

  localparam int TICKP = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       hold_wr = 1'b0;
  logic [7:0] hold_wdata = '0;
  logic       empty_clr = 1'b0;
  logic       tx_en = 1'b1;
  logic       len_short = 1'b0;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       mp_en = 1'b0;
  logic       mp_bit = 1'b0;
  logic       stop_two = 1'b0;
  logic       empty_ie = 1'b0;
  logic       end_ie = 1'b0;
  logic       txd, empty_irq, end_irq, empty_flag, end_flag;

  int checks = 0;
  int fails  = 0;
  int tcnt   = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    tcnt = (tcnt == TICKP - 1) ? 0 : tcnt + 1;
    tick = (tcnt == 0);
  end

  ser_tx_core #(.DATA_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .hold_wr(hold_wr),
    .hold_wdata(hold_wdata), .empty_clr(empty_clr), .tx_en(tx_en),
    .len_short(len_short), .par_en(par_en), .par_odd(par_odd),
    .mp_en(mp_en), .mp_bit(mp_bit), .stop_two(stop_two),
    .empty_ie(empty_ie), .end_ie(end_ie), .txd(txd),
    .empty_irq(empty_irq), .end_irq(end_irq),
    .empty_flag(empty_flag), .end_flag(end_flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected frame: R3 order, R4 length, R5/R6 slot, R7 stops
  function automatic int build(input logic [7:0] d, output logic [15:0] b);
    int n;
    int nd;
    logic p;
    b  = '1;
    n  = 0;
    nd = len_short ? 7 : 8;
    b[n] = 1'b0; n++;
    p = 1'b0;
    for (int i = 0; i < nd; i++) begin
      b[n] = d[i]; n++;
      p = p ^ d[i];
    end
    if (mp_en) begin
      b[n] = mp_bit; n++;
    end else if (par_en) begin
      b[n] = p ^ par_odd; n++;
    end
    b[n] = 1'b1; n++;
    if (stop_two) begin
      b[n] = 1'b1; n++;
    end
    return n;
  endfunction

  task automatic send(input logic [7:0] d);
    @(negedge clk);
    hold_wr = 1'b1; hold_wdata = d;
    @(negedge clk);
    hold_wr = 1'b0; empty_clr = 1'b1;
    @(negedge clk);
    empty_clr = 1'b0;
  endtask

  // R8: every cycle of every cell compared
  task automatic check_frame(input logic [15:0] b, input int n, input bit wait_start,
                             input string req);
    int bad = -1;
    int got = 0;
    int expv = 0;
    if (wait_start) begin
      for (int to = 0; to < 4000 && txd !== 1'b0; to++) @(negedge clk);
    end
    for (int i = 0; i < n; i++) begin
      for (int j = 0; j < TICKP; j++) begin
        if (bad < 0 && txd !== b[i]) begin
          bad = i; got = int'(txd); expv = int'(b[i]);
        end
        @(negedge clk);
      end
    end
    checks++;
    if (bad >= 0) begin
      fails++;
      $display("FAIL %s cell %0d actual=%0d expected=%0d", req, bad, got, expv);
    end
  endtask

  // R10: line rests high and end flag set after a lone frame
  task automatic check_rest(input string req);
    bit ok = 1'b1;
    for (int k = 0; k < 2 * TICKP; k++) begin
      if (txd !== 1'b1 || end_flag !== 1'b1) ok = 1'b0;
      @(negedge clk);
    end
    chk(ok, req, int'(end_flag), 1);
  endtask

  task automatic one_frame(input logic [7:0] d, input string req);
    logic [15:0] b;
    int n;
    n = build(d, b);
    send(d);
    check_frame(b, n, 1'b1, req);
  endtask

  logic [7:0] pats [8] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h80, 8'h7F, 8'h01, 8'hC3};

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R1 reset state
    chk(txd === 1'b1, "R1 txd", int'(txd), 1);
    chk(empty_flag === 1'b1, "R1 empty_flag", int'(empty_flag), 1);
    chk(end_flag === 1'b1, "R1 end_flag", int'(end_flag), 1);
    chk(empty_irq === 1'b0 && end_irq === 1'b0, "R11 irq masked", int'(empty_irq | end_irq), 0);
    empty_ie = 1'b1; end_ie = 1'b1;
    @(negedge clk);
    chk(empty_irq === 1'b1 && end_irq === 1'b1, "R11 irq enabled", int'(empty_irq & end_irq), 1);

    // R2 handshake: empty clears, load sets it and clears end
    @(negedge clk); hold_wr = 1'b1; hold_wdata = 8'h3C;
    @(negedge clk); hold_wr = 1'b0; empty_clr = 1'b1;
    @(negedge clk); empty_clr = 1'b0;
    chk(empty_flag === 1'b0 && empty_irq === 1'b0, "R2 empty cleared", int'(empty_flag), 0);
    for (int to = 0; to < 100 && txd !== 1'b0; to++) @(negedge clk);
    chk(empty_flag === 1'b1 && end_flag === 1'b0, "R2 flags at load",
        int'({empty_flag, end_flag}), 2);
    chk(end_irq === 1'b0, "R11 end_irq follows flag", int'(end_irq), 0);
    for (int to = 0; to < 200 && end_flag !== 1'b1; to++) @(negedge clk);
    repeat (4 * TICKP) @(negedge clk);

    // R3 R8 R10: exhaustive 8-bit data, one stop, no slot
    for (int v = 0; v < 256; v++) begin
      one_frame(8'(v), "R3");
      check_rest("R10");
    end

    // R4 R5 R6 R7: format sweep
    for (int c = 0; c < 20; c++) begin
      len_short = c[0];
      stop_two  = c[1];
      par_en    = (c / 4 == 1) || (c / 4 == 2) || (c / 4 == 4);
      par_odd   = (c / 4 == 2);
      mp_en     = (c / 4 >= 3);
      mp_bit    = (c / 4 == 4);
      for (int p = 0; p < 8; p++) begin
        if (mp_en) one_frame(pats[p], "R6");
        else if (par_en) one_frame(pats[p], "R5");
        else if (stop_two) one_frame(pats[p], "R7");
        else one_frame(pats[p], "R4");
        check_rest("R10");
      end
    end

    // R9 back-to-back frames
    for (int c = 0; c < 4; c++) begin
      logic [15:0] ba, bb;
      int na, nb;
      len_short = c[0]; stop_two = c[1]; par_en = c[0]; par_odd = c[1];
      mp_en = 1'b0;
      na = build(pats[c], ba);
      nb = build(pats[c + 4], bb);
      send(pats[c]);
      fork
        begin
          check_frame(ba, na, 1'b1, "R9 first");
          check_frame(bb, nb, 1'b0, "R9 chained");
        end
        begin
          for (int to = 0; to < 100 && empty_flag !== 1'b1; to++) @(negedge clk);
          send(pats[c + 4]);
        end
      join
      check_rest("R10 after chain");
    end

    // R12 disabled engine
    len_short = 1'b0; stop_two = 1'b0; par_en = 1'b0; mp_en = 1'b0;
    tx_en = 1'b0;
    send(8'h96);
    begin
      bit ok = 1'b1;
      for (int k = 0; k < 10 * TICKP; k++) begin
        if (txd !== 1'b1 || empty_flag !== 1'b0 || end_flag !== 1'b1) ok = 1'b0;
        @(negedge clk);
      end
      chk(ok, "R12 held", int'({txd, empty_flag, end_flag}), 5);
    end
    tx_en = 1'b1;
    begin
      logic [15:0] b;
      int n;
      n = build(8'h96, b);
      check_frame(b, n, 1'b1, "R12 resumes");
    end
    check_rest("R10");

    // R11 masking of end request
    end_ie = 1'b0;
    @(negedge clk);
    chk(end_flag === 1'b1 && end_irq === 1'b0, "R11 end masked", int'(end_irq), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule